// File: doc/BRIEF.md
# Period and Pulse-Width Capture Unit

This block measures one digital input that has already been synchronised to the clock. It runs a cycle counter that restarts on a selectable edge of the input. At that edge, just before the restart, it captures the counter value, which is the period. At the opposite edge it captures the counter value again, which is the time since the last restart, or the pulse width. Software divides the two values to get duty cycle, and inverts the period to get frequency.

There are two capture channels. An assignment select picks which channel receives the period and which receives the width. Each channel has its own capture enable, a flag that marks a value waiting to be read, and a read strobe that clears that flag. A capture that arrives while its channel's flag is still set is dropped and raises a shared sticky error flag. A separate clear input resets the error flag. A measurement-enable input stops and rearms the counter.

Top module: `ppw_capture_unit`

## Requirements
- R1: After reset, both capture values are 0, both channel flags are 0 and the error flag is 0.
- R2: With `width_first`=0, channel 0 receives the period and channel 1 receives the width. The period is the number of clock cycles between two consecutive restart edges. The width is the number of cycles from a restart edge to the next opposite edge.
- R3: With `width_first`=1, the assignment is swapped: channel 0 receives the width and channel 1 receives the period.
- R4: With `invert_sel`=0, the restart edge is the rising edge (0 to 1) and the width edge is the falling edge. With `invert_sel`=1, the restart edge is the falling edge and the width edge is the rising edge.
- R5: An edge is a difference between `sig_in` on one clock edge and `sig_in` on the previous clock edge. While `meas_en`=0, no capture is stored and the counter is held unarmed. The first restart edge after that only starts the counter: it stores no period, and no width is captured before it.
- R6: A channel whose `cap_en` bit is 0 ignores its captures, and its value and flag stay unchanged.
- R7: A capture for a channel whose flag is still set does not change that channel's value and sets `err_flag`.
- R8: `rd_strobe[i]`=1 clears flag i on the next clock edge. A read strobe in the same cycle as a capture counts as reading first, so the capture is stored and the flag stays set.
- R9: The counter stops at 2^CNT_W-1 instead of wrapping. A capture taken after that returns 2^CNT_W-1.
- R10: `err_flag` stays set until `err_clr`=1. If a new overflow happens in the same cycle as `err_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Measurement enable; 0 holds the counter unarmed |
| sig_in | input | 1 | Synchronised input under measurement |
| width_first | input | 1 | 0: period to channel 0; 1: width to channel 0 |
| invert_sel | input | 1 | 0: restart on rising edge; 1: restart on falling edge |
| cap_en | input | 2 | Per-channel capture enable |
| rd_strobe | input | 2 | Per-channel flag clear (value read) |
| err_clr | input | 1 | Clears the error flag |
| cap0_val | output | CNT_W | Channel 0 captured value |
| cap1_val | output | CNT_W | Channel 1 captured value |
| cap_flag | output | 2 | Per-channel value-waiting flags |
| err_flag | output | 1 | Sticky capture-overflow error |

## Verification
Directed waveforms with known high and low lengths are run under each combination of assignment select and invert select. Because the width and period values differ, these runs show whether the channel routing is swapped and whether the restart edge is the wrong polarity. Further directed runs check the arming edge after enable, a disabled channel, an overflow with no read, a read that lands on the capture cycle, and a high pulse longer than the counter range. Random segment lengths, together with random toggling of the selects, enables, strobes and error clear, are then compared every cycle against a bench model. This tests how routing changes interact with pending flags.

// File: rtl/ppw_pkg.sv
// Package ppw_pkg
// Shared types and helpers for the period and pulse-width capture unit.
// Assumes exactly two capture channels; the channel index is one bit.
package ppw_pkg;

    // Which measured quantity lands in channel 0
    typedef enum logic {
        ROUTE_PERIOD_FIRST = 1'b0,
        ROUTE_WIDTH_FIRST  = 1'b1
    } route_mode_e;

    // Events produced by the counter in one cycle
    typedef struct packed {
        logic period_hit;
        logic width_hit;
    } meas_evt_t;

    localparam int unsigned NUM_CHAN = 2;

    // Selects the event that feeds channel ch under the given routing mode
    function automatic logic route_event(input route_mode_e mode,
                                         input int unsigned ch,
                                         input meas_evt_t   evt);
        logic take_period;
        take_period = (mode == ROUTE_PERIOD_FIRST) ? (ch == 0) : (ch != 0);
        return take_period ? evt.period_hit : evt.width_hit;
    endfunction

endpackage

// File: rtl/ppw_edge_detect.sv
// Module ppw_edge_detect
// Finds rising and falling edges of an already synchronised input by
// comparing the present sample with the one registered on the last clock,
// and maps them to restart and width edges according to the invert select.
// Assumes sig_in meets setup to clk; no synchroniser is included here.
module ppw_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic invert_sel,
    output logic restart_edge,
    output logic opposite_edge
);

    logic sig_prev_q;
    logic rise;
    logic fall;

    // Hold the previous sample of the input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_prev_q <= 1'b0;
        end else begin
            sig_prev_q <= sig_in;
        end
    end

    // Raw edges from present versus previous sample
    always_comb begin
        rise = sig_in & ~sig_prev_q;
        fall = ~sig_in & sig_prev_q;
    end

    // Polarity mapping: restart on rise unless inverted
    always_comb begin
        if (invert_sel) begin
            restart_edge  = fall;
            opposite_edge = rise;
        end else begin
            restart_edge  = rise;
            opposite_edge = fall;
        end
    end

endmodule

// File: rtl/ppw_counter.sv
// Module ppw_counter
// Saturating cycle counter that restarts on the restart edge. It reports a
// period event at a restart edge and a width event at an opposite edge,
// both only once armed by an earlier restart edge. cnt_now is the value
// before this cycle's update and is the value to capture.
// Assumes run_en low means "idle": counter cleared and disarmed.
module ppw_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart_edge,
    input  logic             opposite_edge,
    output logic [CNT_W-1:0] cnt_now,
    output ppw_pkg::meas_evt_t evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Arming and counting; restart loads one so a capture equals cycles elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!run_en) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart_edge) begin
            cnt_q   <= CNT_ONE;
            armed_q <= 1'b1;
        end else if (armed_q && (cnt_q != CNT_MAX)) begin
            cnt_q   <= cnt_q + CNT_ONE;
        end
    end

    // Events are valid only while running and armed
    always_comb begin
        cnt_now        = cnt_q;
        evt.period_hit = run_en & armed_q & restart_edge;
        evt.width_hit  = run_en & armed_q & opposite_edge;
    end

endmodule

// File: rtl/ppw_capture_chan.sv
// Module ppw_capture_chan
// One capture channel: stores the sample on a capture event when enabled
// and the flag is clear, sets its flag, and reports an overflow when a
// capture hits a pending flag. A read strobe is applied before the capture
// decision of the same cycle.
// Assumes cap_evt is a single-cycle pulse.
module ppw_capture_chan #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             cap_en,
    input  logic             rd_strobe,
    input  logic [CNT_W-1:0] sample,
    output logic [CNT_W-1:0] val,
    output logic             flag,
    output logic             ovf
);

    logic [CNT_W-1:0] val_q;
    logic             flag_q;
    logic             pending;
    logic             take;

    // Decide between store, overflow or nothing
    always_comb begin
        pending = flag_q & ~rd_strobe;
        take    = cap_evt & cap_en & ~pending;
        ovf     = cap_evt & cap_en & pending;
    end

    // Value and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            flag_q <= 1'b0;
        end else if (take) begin
            val_q  <= sample;
            flag_q <= 1'b1;
        end else begin
            flag_q <= pending;
        end
    end

    // Drive outputs from state
    always_comb begin
        val  = val_q;
        flag = flag_q;
    end

endmodule

// File: rtl/ppw_capture_unit.sv
// Module ppw_capture_unit
// Top of the period and pulse-width capture unit. Joins edge detection,
// the restarting counter and two capture channels, routes the period and
// width events to channels by the assignment select, and keeps a sticky
// error flag for capture overflow.
// Assumes sig_in is already synchronous to clk.
module ppw_capture_unit #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_en,
    input  logic             sig_in,
    input  logic             width_first,
    input  logic             invert_sel,
    input  logic [1:0]       cap_en,
    input  logic [1:0]       rd_strobe,
    input  logic             err_clr,
    output logic [CNT_W-1:0] cap0_val,
    output logic [CNT_W-1:0] cap1_val,
    output logic [1:0]       cap_flag,
    output logic             err_flag
);

    import ppw_pkg::*;

    logic               restart_edge;
    logic               opposite_edge;
    logic [CNT_W-1:0]   cnt_now;
    meas_evt_t          evt;
    route_mode_e        route_mode;
    logic [NUM_CHAN-1:0] chan_evt;
    logic [NUM_CHAN-1:0] chan_ovf;
    logic [CNT_W-1:0]   chan_val [NUM_CHAN];
    logic               err_q;

    ppw_edge_detect u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_in       (sig_in),
        .invert_sel   (invert_sel),
        .restart_edge (restart_edge),
        .opposite_edge(opposite_edge)
    );

    ppw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (meas_en),
        .restart_edge (restart_edge),
        .opposite_edge(opposite_edge),
        .cnt_now      (cnt_now),
        .evt          (evt)
    );

    // Routing mode from the plain select port
    always_comb begin
        route_mode = width_first ? ROUTE_WIDTH_FIRST : ROUTE_PERIOD_FIRST;
    end

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        // Event for this channel under the current routing
        always_comb begin
            chan_evt[ch] = route_event(route_mode, ch, evt);
        end

        ppw_capture_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_evt  (chan_evt[ch]),
            .cap_en   (cap_en[ch]),
            .rd_strobe(rd_strobe[ch]),
            .sample   (cnt_now),
            .val      (chan_val[ch]),
            .flag     (cap_flag[ch]),
            .ovf      (chan_ovf[ch])
        );
    end

    // Sticky error: overflow sets, clear input resets, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (|chan_ovf) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    // Output mapping
    always_comb begin
        cap0_val = chan_val[0];
        cap1_val = chan_val[1];
        err_flag = err_q;
    end

endmodule

// File: rtl/ppw_capture_unit_chk.sv
// Module ppw_capture_unit_chk
// Property checker for ppw_capture_unit, attached with bind below.
module ppw_capture_unit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_en,
    input logic [1:0]       cap_en,
    input logic [1:0]       rd_strobe,
    input logic             err_clr,
    input logic [CNT_W-1:0] cap0_val,
    input logic [CNT_W-1:0] cap1_val,
    input logic [1:0]       cap_flag,
    input logic             err_flag,
    input logic [1:0]       chan_evt,
    input logic             restart_edge,
    input logic [CNT_W-1:0] cnt_now
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_OVF_KEEPS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_evt[0] && cap_en[0] && cap_flag[0] && !rd_strobe[0]) |=> ($stable(cap0_val) && err_flag)); // R7
    AST_OVF_KEEPS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_evt[1] && cap_en[1] && cap_flag[1] && !rd_strobe[1]) |=> ($stable(cap1_val) && err_flag)); // R7
    AST_DISABLED_CH0_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[0] |=> $stable(cap0_val)); // R6
    AST_DISABLED_CH1_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en[1] |=> $stable(cap1_val)); // R6
    AST_READ_CLEARS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe[0] && !(chan_evt[0] && cap_en[0])) |=> !cap_flag[0]); // R8
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> ($stable(cap0_val) && $stable(cap1_val))); // R5
    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && cnt_now == CNT_MAX && !restart_edge) |=> (cnt_now == CNT_MAX)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R10
    AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_flag[0] && !chan_evt[0]) |=> !cap_flag[0]); // R2

endmodule

bind ppw_capture_unit ppw_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_en     (meas_en),
    .cap_en      (cap_en),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .cap0_val    (cap0_val),
    .cap1_val    (cap1_val),
    .cap_flag    (cap_flag),
    .err_flag    (err_flag),
    .chan_evt    (chan_evt),
    .restart_edge(restart_edge),
    .cnt_now     (cnt_now)
);

// File: tb/test_ppw_capture_unit.sv
module test_ppw_capture_unit;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned W   = 10;
    localparam int unsigned MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         meas_en = 1'b0;
    logic         sig_in = 1'b0;
    logic         width_first = 1'b0;
    logic         invert_sel = 1'b0;
    logic [1:0]   cap_en = 2'b00;
    logic [1:0]   rd_strobe = 2'b00;
    logic         err_clr = 1'b0;
    logic [W-1:0] cap0_val;
    logic [W-1:0] cap1_val;
    logic [1:0]   cap_flag;
    logic         err_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state, derived from the requirements
    bit          m_prev;
    bit          m_armed;
    int unsigned m_cnt;
    int unsigned m_val [2];
    bit          m_flag [2];
    bit          m_err;

    always #2.5 clk = ~clk;

    ppw_capture_unit #(.CNT_W(W)) i_ppw_capture_unit (
        .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .sig_in(sig_in),
        .width_first(width_first), .invert_sel(invert_sel), .cap_en(cap_en),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .cap0_val(cap0_val),
        .cap1_val(cap1_val), .cap_flag(cap_flag), .err_flag(err_flag)
    );

    task automatic check(input int unsigned act, input int unsigned exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_armed = 0; m_cnt = 0;
        m_val[0] = 0; m_val[1] = 0; m_flag[0] = 0; m_flag[1] = 0; m_err = 0;
    endtask

    // One clock edge of expected behaviour (R2-R10)
    task automatic model_step();
        bit rise, fall, rs, op, pev, wev, ovf;
        bit ev [2];
        int unsigned snap;
        rise = sig_in && !m_prev;
        fall = !sig_in && m_prev;
        rs = invert_sel ? fall : rise;
        op = invert_sel ? rise : fall;
        snap = m_cnt;
        pev = 0; wev = 0;
        if (!meas_en) begin
            m_armed = 0; m_cnt = 0;
        end else begin
            pev = rs && m_armed;
            wev = op && m_armed;
            if (rs) begin
                m_armed = 1; m_cnt = 1;
            end else if (m_armed && m_cnt != MAXV) begin
                m_cnt++;
            end
        end
        ev[0] = width_first ? wev : pev;
        ev[1] = width_first ? pev : wev;
        ovf = 0;
        for (int i = 0; i < 2; i++) begin
            bit pend;
            pend = m_flag[i] && !rd_strobe[i];
            if (ev[i] && cap_en[i]) begin
                if (pend) begin
                    ovf = 1;
                    m_flag[i] = 1;
                end else begin
                    m_val[i] = snap;
                    m_flag[i] = 1;
                end
            end else begin
                m_flag[i] = pend;
            end
        end
        if (ovf) m_err = 1;
        else if (err_clr) m_err = 0;
        m_prev = sig_in;
    endtask

    // Apply current inputs for one cycle, update model, compare mid-cycle
    task automatic step();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        check(cap0_val, m_val[0], "R2 R3 model cap0");
        check(cap1_val, m_val[1], "R2 R3 model cap1");
        check(cap_flag[0], m_flag[0], "R8 model flag0");
        check(cap_flag[1], m_flag[1], "R8 model flag1");
        check(err_flag, m_err, "R7 R10 model err");
    endtask

    task automatic level(input bit v, input int n);
        for (int k = 0; k < n; k++) begin
            sig_in = v;
            step();
        end
    endtask

    // Disarm, clear flags, set up a directed case
    task automatic prep(input bit wf, input bit inv, input bit [1:0] en);
        meas_en = 0; sig_in = 0; rd_strobe = 2'b11;
        step();
        rd_strobe = 2'b00; width_first = wf; invert_sel = inv; cap_en = en;
        meas_en = 1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(cap0_val, 0, "R1 reset cap0");
        check(cap1_val, 0, "R1 reset cap1");
        check(cap_flag, 0, "R1 reset flags");
        check(err_flag, 0, "R1 reset err");

        // R5: idle input toggles capture nothing
        cap_en = 2'b11;
        for (int k = 0; k < 6; k++) level(k[0], 2);
        check(cap_flag, 0, "R5 idle no flags");

        // R2 period-first, R5 arming edge stores nothing
        prep(0, 0, 2'b11);
        level(0, 2); level(1, 1);
        check(cap_flag, 0, "R5 first restart edge stores no period");
        level(1, 3); level(0, 6); level(1, 1);
        check(cap0_val, 10, "R2 period in ch0");
        check(cap1_val, 4, "R2 width in ch1");

        // R3 width-first
        prep(1, 0, 2'b11);
        level(0, 2); level(1, 3); level(0, 5); level(1, 1);
        check(cap0_val, 3, "R3 width in ch0");
        check(cap1_val, 8, "R3 period in ch1");

        // R4 inverted restart edge
        prep(0, 1, 2'b11);
        level(1, 2); level(0, 3); level(1, 4); level(0, 1);
        check(cap0_val, 7, "R4 period on falling restart");
        check(cap1_val, 3, "R4 width to rising edge");

        // R6 channel 1 disabled
        prep(0, 0, 2'b01);
        level(0, 2); level(1, 5); level(0, 5); level(1, 1);
        check(cap0_val, 10, "R6 enabled ch0 captures");
        check(cap1_val, 3, "R6 disabled ch1 value kept");
        check(cap_flag[1], 0, "R6 disabled ch1 flag kept");

        // R7 overflow with ch0 flag pending
        level(1, 1); level(0, 2); level(1, 1);
        check(cap0_val, 10, "R7 overflow value not stored");
        check(err_flag, 1, "R7 overflow sets err");

        // R10 clear
        err_clr = 1; level(1, 1); err_clr = 0;
        check(err_flag, 0, "R10 err cleared");

        // R8 read on the capture cycle stores
        level(0, 3);
        rd_strobe = 2'b01; level(1, 1); rd_strobe = 2'b00;
        check(cap0_val, 5, "R8 same-cycle read then store");
        check(cap_flag[0], 1, "R8 flag stays set");
        rd_strobe = 2'b01; level(1, 1); rd_strobe = 2'b00;
        check(cap_flag[0], 0, "R8 read clears flag");

        // R9 saturation of a long pulse
        prep(0, 0, 2'b11);
        level(0, 2); level(1, 1); level(1, 1100); level(0, 1);
        check(cap1_val, MAXV, "R9 saturated width");

        // Random phase against the model
        for (int s = 0; s < 3000; s++) begin
            int len;
            len = 1 + int'($urandom_range(19));
            if ($urandom_range(19) == 0) width_first = ~width_first;
            if ($urandom_range(19) == 0) invert_sel = ~invert_sel;
            if ($urandom_range(9) == 0) cap_en = 2'($urandom_range(3));
            meas_en = ($urandom_range(39) != 0);
            for (int k = 0; k < len; k++) begin
                sig_in = s[0];
                rd_strobe = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
                err_clr = ($urandom_range(15) == 0);
                step();
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule